// File: doc/BRIEF.md
# Split Instruction/Data Cache with Parity Fault Flush

This block is a small direct-mapped cache with one array for instruction fetches and another for data reads. Each array is protected by parity. Every hit read is checked, and errors are detected but never corrected. When a check fails, the read is not returned. The block pulses a machine-check strobe that names the array at fault, then sweeps that array and clears every valid bit, one line per cycle. After the sweep, the stalled read is served again as an ordinary miss.

Addresses inside a parameterised uncached window, which is meant for the stack, the heap and the exception vectors, never allocate a line and always go to backing memory. Addresses are used as given, with no translation stage. Both arrays share one request/response port to backing memory, with at most one read outstanding at a time. Memory returns each word together with its per-byte parity. The cache stores that parity as it arrives, so a word that was corrupted before it reached the cache is caught on its first later hit. A requester raises its `*_req_valid` and holds the address steady until it sees a one-cycle `*_rsp_valid`. It then drops the request.

Top module: `pcache_top`

## Requirements
- R1: After synchronous reset, every line of both arrays is invalid. No response, machine-check, busy or memory request is asserted.
- R2: A cacheable read that misses issues exactly one memory read of its address. It returns the memory word and allocates the line, and its response comes 4 cycles after the request when memory answers one cycle after its request.
- R3: A cacheable read that hits, with good parity, returns the stored word 1 cycle after the request, with no memory read.
- R4: Memory delivers per-byte even parity, where parity bit k equals the XOR of data bits 8k+7..8k. A hit whose stored data or tag parity is inconsistent is not returned. Instead `mc_stb` pulses for exactly one cycle, one cycle after the request. `mc_src` bit 0 marks the instruction array and bit 1 marks the data array.
- R5: After a fault, `busy` for that array stays high for exactly LINES cycles and every line of that array becomes invalid. The other array keeps its contents.
- R6: The faulting read is held during the sweep and then served as a miss with one memory read, so its response comes LINES+5 cycles after the request.
- R7: A read inside [UC_BASE, UC_LIMIT) never allocates a line. Every such read goes to memory and takes miss latency, even when repeated.
- R8: When both arrays wait for memory in the same cycle, the data array's read is issued first. Only one memory read is outstanding at a time.
- R9: Two cacheable addresses that share an index evict each other, so alternating reads between them always miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_req_valid | input | 1 | Instruction read request, held until response |
| i_req_addr | input | 16 | Instruction byte address, word aligned |
| i_rsp_valid | output | 1 | Instruction response strobe |
| i_rsp_data | output | 32 | Instruction read data |
| i_busy | output | 1 | Instruction array invalidation sweep in progress |
| d_req_valid | input | 1 | Data read request, held until response |
| d_req_addr | input | 16 | Data byte address, word aligned |
| d_rsp_valid | output | 1 | Data response strobe |
| d_rsp_data | output | 32 | Data read data |
| d_busy | output | 1 | Data array invalidation sweep in progress |
| mc_stb | output | 1 | Machine-check strobe |
| mc_src | output | 2 | Fault source: bit 0 instruction, bit 1 data |
| mem_req_valid | output | 1 | Backing memory read strobe |
| mem_req_addr | output | 16 | Backing memory read address |
| mem_rsp_valid | input | 1 | Backing memory response strobe |
| mem_rsp_data | input | 32 | Backing memory data |
| mem_rsp_par | input | 4 | Per-byte parity from backing memory |

## Verification
A hit answers 1 cycle after the request. A lone miss answers 4 cycles after it: one cycle for the lookup, one for the registered memory strobe, one for the memory model and one for the fill. A parity fault answers LINES+5 cycles after the request. Its machine-check pulse comes 1 cycle after the request, and busy lasts LINES cycles. The bench drives requests and samples every output on the falling edge. It counts cycles from the request edge to the response strobe, counts machine-check and busy cycles within that window, and compares each count with these figures. Memory reads are counted at the memory port, so a hit, an uncached read or a post-sweep refill is told apart by its read count as well as by its latency.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
    localparam int unsigned PC_ADDR_W = 16;
    localparam int unsigned PC_DATA_W = 32;
    localparam int unsigned PC_LANES  = PC_DATA_W / 8;

    typedef logic [PC_ADDR_W-1:0] addr_t;
    typedef logic [PC_DATA_W-1:0] data_t;
    typedef logic [PC_LANES-1:0]  lpar_t;

    typedef enum logic [1:0] {CS_IDLE, CS_MISS, CS_FLUSH, CS_RESP} cstate_e;
    typedef enum logic {AS_IDLE, AS_WAIT} astate_e;

    typedef struct packed {
        data_t data;
        lpar_t par;
    } fill_t;

    function automatic lpar_t lane_parity(data_t d);
        lpar_t p;
        for (int k = 0; k < PC_LANES; k++) p[k] = ^d[8*k +: 8];
        return p;
    endfunction

    function automatic logic in_window(addr_t a, addr_t lo, addr_t hi);
        return (a >= lo) && (a < hi);
    endfunction
endpackage

// File: rtl/pcache_store.sv
module pcache_store
    import pcache_pkg::*;
#(
    parameter int unsigned LINES = 16,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned TAG_W = PC_ADDR_W - 2 - IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit_raw,
    output logic             par_bad,
    output data_t            rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  fill_t            wr_fill,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);
    logic [LINES-1:0] valid;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic             tpar_q [LINES];
    data_t            data_q [LINES];
    lpar_t            dpar_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
        end else if (clr_en) begin
            valid[clr_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            tpar_q[wr_idx] <= ^{1'b1, wr_tag};
            data_q[wr_idx] <= wr_fill.data;
            dpar_q[wr_idx] <= wr_fill.par;
        end
    end

    logic tag_ok, data_ok;
    always_comb begin
        hit_raw = valid[look_idx] && (tag_q[look_idx] == look_tag);
        tag_ok  = (^{valid[look_idx], tag_q[look_idx]}) == tpar_q[look_idx];
        data_ok = lane_parity(data_q[look_idx]) == dpar_q[look_idx];
        par_bad = hit_raw && !(tag_ok && data_ok);
        rd_data = data_q[look_idx];
    end

    p_wr_clr_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && clr_en));
    p_clear_line_r5: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !valid[$past(clr_idx)]);
    p_fill_sets_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid[$past(wr_idx)]);
endmodule

// File: rtl/pcache_side.sv
module pcache_side
    import pcache_pkg::*;
#(
    parameter int unsigned LINES    = 16,
    parameter addr_t       UC_BASE  = 16'h8000,
    parameter addr_t       UC_LIMIT = 16'h9000,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned TAG_W = PC_ADDR_W - 2 - IDX_W
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  addr_t req_addr,
    output logic  rsp_valid,
    output data_t rsp_data,
    output logic  busy,
    output logic  mc_stb,
    output logic  mreq,
    output addr_t maddr,
    input  logic  fill_valid,
    input  fill_t fill
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    cstate_e          state;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             uc, hit_raw, par_bad, wr_en;
    data_t            rd_data;

    assign idx   = req_addr[2 +: IDX_W];
    assign tag   = req_addr[PC_ADDR_W-1 -: TAG_W];
    assign uc    = in_window(req_addr, UC_BASE, UC_LIMIT);
    assign wr_en = (state == CS_MISS) && fill_valid && !uc;

    pcache_store #(.LINES(LINES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .look_idx (idx),
        .look_tag (tag),
        .hit_raw  (hit_raw),
        .par_bad  (par_bad),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (idx),
        .wr_tag   (tag),
        .wr_fill  (fill),
        .clr_en   (state == CS_FLUSH),
        .clr_idx  (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CS_IDLE;
            cnt      <= '0;
            mc_stb   <= 1'b0;
            rsp_data <= '0;
        end else begin
            mc_stb <= 1'b0;
            unique case (state)
                CS_IDLE: if (req_valid) begin
                    if (uc || !hit_raw) begin
                        state <= CS_MISS;
                    end else if (par_bad) begin
                        state  <= CS_FLUSH;
                        cnt    <= '0;
                        mc_stb <= 1'b1;
                    end else begin
                        state    <= CS_RESP;
                        rsp_data <= rd_data;
                    end
                end
                CS_MISS: if (fill_valid) begin
                    state    <= CS_RESP;
                    rsp_data <= fill.data;
                end
                CS_FLUSH: begin
                    if (cnt == LAST) state <= CS_IDLE;
                    else             cnt   <= cnt + 1'b1;
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    assign rsp_valid = (state == CS_RESP);
    assign busy      = (state == CS_FLUSH);
    assign mreq      = (state == CS_MISS);
    assign maddr     = req_addr;

    p_fault_enters_sweep_r4: assert property (@(posedge clk) disable iff (rst)
        mc_stb |-> busy && !rsp_valid);
    p_sweep_starts_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> cnt == '0);
    p_sweep_ends_at_last_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cnt) == LAST);
    p_uc_never_writes_r7: assert property (@(posedge clk) disable iff (rst)
        (mreq && uc) |-> !wr_en);
endmodule

// File: rtl/pcache_arb.sv
module pcache_arb
    import pcache_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mreq,
    input  addr_t      maddr [2],
    output logic [1:0] fill_valid,
    output logic       mem_req_valid,
    output addr_t      mem_req_addr,
    input  logic       mem_rsp_valid
);
    astate_e ast;
    logic    owner;

    always_ff @(posedge clk) begin
        if (rst) begin
            ast           <= AS_IDLE;
            owner         <= 1'b0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
        end else begin
            mem_req_valid <= 1'b0;
            unique case (ast)
                AS_IDLE: if (|mreq) begin
                    owner         <= mreq[1];
                    mem_req_addr  <= mreq[1] ? maddr[1] : maddr[0];
                    mem_req_valid <= 1'b1;
                    ast           <= AS_WAIT;
                end
                AS_WAIT: if (mem_rsp_valid) ast <= AS_IDLE;
                default: ast <= AS_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_fill
        assign fill_valid[g] = (ast == AS_WAIT) && mem_rsp_valid && (owner == 1'(g));
        p_fill_to_waiter_r8: assert property (@(posedge clk) disable iff (rst)
            fill_valid[g] |-> mreq[g]);
    end

    p_single_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);
    p_data_first_r8: assert property (@(posedge clk) disable iff (rst)
        (ast == AS_IDLE && mreq[1]) |=> (owner && mem_req_valid));
endmodule

// File: rtl/pcache_top.sv
module pcache_top
    import pcache_pkg::*;
#(
    parameter int unsigned LINES    = 16,
    parameter addr_t       UC_BASE  = 16'h8000,
    parameter addr_t       UC_LIMIT = 16'h9000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_req_valid,
    input  logic [PC_ADDR_W-1:0] i_req_addr,
    output logic                 i_rsp_valid,
    output logic [PC_DATA_W-1:0] i_rsp_data,
    output logic                 i_busy,
    input  logic                 d_req_valid,
    input  logic [PC_ADDR_W-1:0] d_req_addr,
    output logic                 d_rsp_valid,
    output logic [PC_DATA_W-1:0] d_rsp_data,
    output logic                 d_busy,
    output logic                 mc_stb,
    output logic [1:0]           mc_src,
    output logic                 mem_req_valid,
    output logic [PC_ADDR_W-1:0] mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [PC_DATA_W-1:0] mem_rsp_data,
    input  logic [PC_LANES-1:0]  mem_rsp_par
);
    logic [1:0] req_v, rsp_v, busy_v, mc_v, mreq, fill_v;
    addr_t      req_a [2];
    addr_t      maddr [2];
    data_t      rsp_d [2];
    fill_t      fill;

    assign req_v    = {d_req_valid, i_req_valid};
    assign req_a[0] = i_req_addr;
    assign req_a[1] = d_req_addr;
    assign fill     = '{data: mem_rsp_data, par: mem_rsp_par};

    for (genvar s = 0; s < 2; s++) begin : g_side
        pcache_side #(.LINES(LINES), .UC_BASE(UC_BASE), .UC_LIMIT(UC_LIMIT)) u_side (
            .clk        (clk),
            .rst        (rst),
            .req_valid  (req_v[s]),
            .req_addr   (req_a[s]),
            .rsp_valid  (rsp_v[s]),
            .rsp_data   (rsp_d[s]),
            .busy       (busy_v[s]),
            .mc_stb     (mc_v[s]),
            .mreq       (mreq[s]),
            .maddr      (maddr[s]),
            .fill_valid (fill_v[s]),
            .fill       (fill)
        );
    end

    pcache_arb u_arb (
        .clk           (clk),
        .rst           (rst),
        .mreq          (mreq),
        .maddr         (maddr),
        .fill_valid    (fill_v),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid)
    );

    assign i_rsp_valid = rsp_v[0];
    assign i_rsp_data  = rsp_d[0];
    assign i_busy      = busy_v[0];
    assign d_rsp_valid = rsp_v[1];
    assign d_rsp_data  = rsp_d[1];
    assign d_busy      = busy_v[1];
    assign mc_stb      = |mc_v;
    assign mc_src      = mc_v;

    p_idle_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !mc_stb && !mem_req_valid && !i_rsp_valid && !d_rsp_valid);
endmodule

// File: tb/pcache_top_bench.sv
module pcache_top_bench;
    import pcache_pkg::*;

    localparam int LINES = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic i_req_valid = 1'b0, d_req_valid = 1'b0;
    addr_t i_req_addr = '0, d_req_addr = '0;
    logic i_rsp_valid, d_rsp_valid, i_busy, d_busy, mc_stb, mem_req_valid;
    data_t i_rsp_data, d_rsp_data;
    logic [1:0] mc_src;
    addr_t mem_req_addr;
    logic  mem_rsp_valid;
    data_t mem_rsp_data;
    lpar_t mem_rsp_par;

    pcache_top #(.LINES(LINES)) u_pcache_top (
        .clk(clk), .rst(rst),
        .i_req_valid(i_req_valid), .i_req_addr(i_req_addr),
        .i_rsp_valid(i_rsp_valid), .i_rsp_data(i_rsp_data), .i_busy(i_busy),
        .d_req_valid(d_req_valid), .d_req_addr(d_req_addr),
        .d_rsp_valid(d_rsp_valid), .d_rsp_data(d_rsp_data), .d_busy(d_busy),
        .mc_stb(mc_stb), .mc_src(mc_src),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_par(mem_rsp_par)
    );

    function automatic data_t word_of(addr_t a);
        return {~a, a};
    endfunction

    // Backing memory: answers one cycle after each request, optionally with a bad lane 0 parity.
    logic  poison_en = 1'b0;
    addr_t poison_addr = '0;
    int    mem_reqs = 0;
    addr_t hist [8];
    always @(posedge clk) begin
        if (rst) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            mem_rsp_par   <= '0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= word_of(mem_req_addr);
                mem_rsp_par   <= lane_parity(word_of(mem_req_addr)) ^
                                 ((poison_en && mem_req_addr == poison_addr) ? lpar_t'(1) : lpar_t'(0));
                hist[mem_reqs % 8] <= mem_req_addr;
                mem_reqs <= mem_reqs + 1;
            end
        end
    end

    int n_cmp = 0, n_bad = 0;
    task automatic check(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic side, input addr_t a, output data_t d, output int lat,
                           output int mcs, output logic [1:0] src, output int busy_n, output int reqs);
        int base;
        @(negedge clk);
        base = mem_reqs;
        if (side) begin d_req_addr = a; d_req_valid = 1'b1; end
        else      begin i_req_addr = a; i_req_valid = 1'b1; end
        lat = 0; mcs = 0; src = '0; busy_n = 0; d = '0;
        forever begin
            @(negedge clk);
            lat++;
            if (mc_stb) begin mcs++; src = src | mc_src; end
            if (side ? d_busy : i_busy) busy_n++;
            if (side ? d_rsp_valid : i_rsp_valid) begin
                d = side ? d_rsp_data : i_rsp_data;
                break;
            end
            if (lat > 500) break;
        end
        d_req_valid = 1'b0;
        i_req_valid = 1'b0;
        reqs = mem_reqs - base;
    endtask

    typedef struct packed {
        logic       side;   // 0 instruction, 1 data
        logic [15:0] addr;
        logic [1:0] kind;   // 0 miss, 1 hit, 2 uncached, 3 conflict miss
    } vec_t;

    localparam vec_t VT [12] = '{
        '{1'b1, 16'h0100, 2'd0}, '{1'b1, 16'h0100, 2'd1},
        '{1'b0, 16'h0100, 2'd0}, '{1'b0, 16'h0100, 2'd1},
        '{1'b1, 16'h0504, 2'd0}, '{1'b1, 16'h0904, 2'd3},
        '{1'b1, 16'h0504, 2'd3}, '{1'b1, 16'h0504, 2'd1},
        '{1'b1, 16'h8000, 2'd2}, '{1'b1, 16'h8000, 2'd2},
        '{1'b0, 16'h8004, 2'd2}, '{1'b0, 16'h8004, 2'd2}
    };

    logic done = 1'b0;
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        data_t d; int lat, mcs, bn, rq; logic [1:0] src;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        check("R1 rsp", {i_rsp_valid, d_rsp_valid}, 0);
        check("R1 busy", {i_busy, d_busy}, 0);
        check("R1 mc", mc_stb, 0);
        check("R1 memreq", mem_req_valid, 0);

        for (int i = 0; i < 12; i++) begin
            string rt;
            rt = (VT[i].kind == 2'd1) ? "R3" : (VT[i].kind == 2'd2) ? "R7" :
                 (VT[i].kind == 2'd3) ? "R9" : (i == 0) ? "R1" : "R2";
            do_read(VT[i].side, VT[i].addr, d, lat, mcs, src, bn, rq);
            check($sformatf("%s data v%0d", rt, i), d, word_of(VT[i].addr));
            check($sformatf("%s latency v%0d", rt, i), lat, (VT[i].kind == 2'd1) ? 1 : 4);
            check($sformatf("%s memreads v%0d", rt, i), rq, (VT[i].kind == 2'd1) ? 0 : 1);
            check($sformatf("R4 no mc v%0d", i), mcs, 0);
        end

        // Data-array fault: store a word with bad parity, then hit it.
        poison_addr = 16'h0200; poison_en = 1'b1;
        do_read(1'b1, 16'h0200, d, lat, mcs, src, bn, rq);
        poison_en = 1'b0;
        check("R2 poisoned fill data", d, word_of(16'h0200));
        do_read(1'b0, 16'h0300, d, lat, mcs, src, bn, rq);
        do_read(1'b1, 16'h0208, d, lat, mcs, src, bn, rq);
        do_read(1'b1, 16'h0200, d, lat, mcs, src, bn, rq);
        check("R4 mc pulses", mcs, 1);
        check("R4 mc_src data", src, 2'b10);
        check("R5 busy cycles", bn, LINES);
        check("R6 latency", lat, LINES + 5);
        check("R6 memreads", rq, 1);
        check("R6 data", d, word_of(16'h0200));
        do_read(1'b1, 16'h0208, d, lat, mcs, src, bn, rq);
        check("R5 data array swept", lat, 4);
        do_read(1'b0, 16'h0300, d, lat, mcs, src, bn, rq);
        check("R5 instr array kept", lat, 1);
        check("R5 instr data", d, word_of(16'h0300));

        // Instruction-array fault.
        poison_addr = 16'h0400; poison_en = 1'b1;
        do_read(1'b0, 16'h0400, d, lat, mcs, src, bn, rq);
        poison_en = 1'b0;
        do_read(1'b0, 16'h0400, d, lat, mcs, src, bn, rq);
        check("R4 mc_src instr", src, 2'b01);
        check("R4 instr mc pulses", mcs, 1);
        check("R5 instr busy", bn, LINES);
        check("R6 instr latency", lat, LINES + 5);

        // R8: both arrays miss in the same cycle.
        begin
            int base; logic gi, gd; data_t di, dd;
            @(negedge clk);
            base = mem_reqs;
            i_req_addr = 16'h0600; d_req_addr = 16'h0700;
            i_req_valid = 1'b1; d_req_valid = 1'b1;
            gi = 1'b0; gd = 1'b0; di = '0; dd = '0;
            for (int c = 0; c < 50 && !(gi && gd); c++) begin
                @(negedge clk);
                if (i_rsp_valid) begin gi = 1'b1; di = i_rsp_data; i_req_valid = 1'b0; end
                if (d_rsp_valid) begin gd = 1'b1; dd = d_rsp_data; d_req_valid = 1'b0; end
            end
            check("R8 both answered", {gi, gd}, 2'b11);
            check("R8 data first", hist[base % 8], 16'h0700);
            check("R8 instr second", hist[(base + 1) % 8], 16'h0600);
            check("R8 read count", mem_reqs - base, 2);
            check("R8 instr data", di, word_of(16'h0600));
            check("R8 data data", dd, word_of(16'h0700));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule